// File: doc/BRIEF.md
# PCI Interrupt and Error Aggregator

This block gathers every interrupt source of a PCI host bridge and presents it to the system as one or more level-sensitive interrupt lines. The sources are the four active-low legacy interrupt pins INTA#..INTD#, four error events (system error, master abort, target abort, parity error) and two DMA events (transfer done, transfer error). Each pin has its own enable bit. Each event sets a sticky flag. Software clears a flag by writing a one to its status bit.

A 2-bit strap selects one of four routing modes. In the two low modes a single shared output carries the interrupt pins and the errors. In the two high modes each pin has its own output and the errors ride on the INTA output. In both cases the odd mode moves the DMA events onto a dedicated fifth output. Software sees a control word and a status word over an APB slave. Two control bits are also driven out as plain pins: a bus reset request and an enable for an error response on illegal accesses.

Top module: `pci_irq_agg`

## Requirements
- R1: After reset the control word reads 0 and every sticky flag is 0. All system interrupt outputs are low, and the synchronized pin field of status (bits 11:8) reads 4'hF.
- R2: A write to offset 0x0 stores bits 31 (bus reset request), 27 (system-error signalling enable), 25 (error interrupt enable), 24 (error response enable) and 3:0 (enables for INTA..INTD in bit order 0..3). All other control bits read 0. Bit 31 drives `pci_rst_req` and bit 24 drives `err_resp_en`.
- R3: Status bits 11:8 show the levels of INTA#..INTD# (bit 8 = INTA#) after a two-stage synchronizer. A change on a pin appears in status after the second rising clock edge, and a pending line reads 0.
- R4: A one-cycle pulse on `evt_pulse[k]` sets a sticky flag that reads at status bit 12+k. The mapping is k=0 parity error, 1 target abort, 2 master abort, 3 DMA error, 4 DMA done, 5 system error. The flag stays set until it is cleared.
- R5: A write to offset 0x4 clears each flag whose bit among 17:12 is 1 and leaves the others unchanged. If an event arrives in the same cycle as the clear of its flag, the flag stays set.
- R6: A pin whose enable bit is 0 never asserts any system interrupt output.
- R7: In mode 0, `irq_out[0]` is the OR of the enabled pending pins, the error request and the DMA request, and `irq_out[4:1]` stay low. The DMA request is the OR of the DMA done and DMA error flags.
- R8: In mode 1, `irq_out[0]` carries the enabled pins and the error request, `irq_out[4]` carries the DMA request, and `irq_out[3:1]` stay low.
- R9: In mode 2, `irq_out[i]` carries enabled pin i (i = 0..3, INTA on bit 0). The error request and the DMA request are ORed onto `irq_out[0]`, and `irq_out[4]` stays low.
- R10: In mode 3, routing is as in mode 2, except that the DMA request goes to `irq_out[4]` instead of `irq_out[0]`.
- R11: The error request is raised only while control bit 25 is 1. It then covers the parity, target-abort and master-abort flags, and also the system-error flag when control bit 27 is 1.
- R12: Each output is registered. It follows its sources one clock after they change, and it drops in the first cycle after its last source is cleared or masked.
- R13: Status bits 25:24 report the `irq_mode` input, and writes do not change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | ADDR_W | APB byte address (0x0 control, 0x4 status) |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pci_int_n | input | 4 | INTA#..INTD#, active low, asynchronous |
| evt_pulse | input | 6 | One-cycle error and DMA event pulses |
| irq_mode | input | 2 | Routing mode strap |
| irq_out | output | 5 | System interrupt lines |
| pci_rst_req | output | 1 | Bus reset request (control bit 31) |
| err_resp_en | output | 1 | Error response enable (control bit 24) |

## Verification
Two functions of the block can act on the same sticky flag in the same cycle: a software write-1-to-clear and a new event pulse. The bench forces this collision directly by driving the system-error pulse during the APB access phase of a write that clears that flag. It then reads status and expects the flag still set. Random phases also mix event pulses with random status writes, and every cycle a bench model compares the interrupt outputs and the readback of status.

// File: rtl/pci_irq_pkg.sv
package pci_irq_pkg;

    localparam int NUM_LINES = 4;
    localparam int NUM_EVT   = 6;
    localparam int NUM_IRQ   = 5;

    // event / flag indices
    localparam int EV_PAR     = 0;
    localparam int EV_TABT    = 1;
    localparam int EV_MABT    = 2;
    localparam int EV_DMAERR  = 3;
    localparam int EV_DMADONE = 4;
    localparam int EV_SYSERR  = 5;

    // control word bit positions
    localparam int CB_BUS_RST  = 31;
    localparam int CB_SIG_EN   = 27;
    localparam int CB_ERR_IE   = 25;
    localparam int CB_ERR_RESP = 24;

    // status word field positions
    localparam int SB_MODE_LO = 24;
    localparam int SB_FLAG_LO = 12;
    localparam int SB_PIN_LO  = 8;

    typedef enum logic [1:0] {
        MODE_ALL_SHARED = 2'd0,
        MODE_SHARED_DMA = 2'd1,
        MODE_PER_LINE   = 2'd2,
        MODE_LINE_DMA   = 2'd3
    } irq_mode_e;

    typedef struct packed {
        logic                 bus_rst;
        logic                 sig_en;
        logic                 err_ie;
        logic                 err_resp;
        logic [NUM_LINES-1:0] line_en;
    } ctrl_t;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [NUM_IRQ-1:0] irq;
    } agg_state_t;

endpackage

// File: rtl/pci_irq_sync.sv
module pci_irq_sync #(
    parameter int                WIDTH   = 4,
    parameter int                STAGES  = 2,
    parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb chain_d[s] = din;
            end else begin : g_next
                always_comb chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/pci_irq_flags.sv
module pci_irq_flags #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_q
);

    logic [N-1:0] flags_d;

    // a set in the same cycle as a clear wins
    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/pci_irq_route.sv
module pci_irq_route
    import pci_irq_pkg::*;
(
    input  irq_mode_e            mode,
    input  logic [NUM_LINES-1:0] line_pend,
    input  logic                 err_pend,
    input  logic                 dma_pend,
    output logic [NUM_IRQ-1:0]   irq_d
);

    always_comb begin
        irq_d = '0;
        unique case (mode)
            MODE_ALL_SHARED: begin
                irq_d[0] = (|line_pend) | err_pend | dma_pend;
            end
            MODE_SHARED_DMA: begin
                irq_d[0] = (|line_pend) | err_pend;
                irq_d[NUM_IRQ-1] = dma_pend;
            end
            MODE_PER_LINE: begin
                irq_d[NUM_LINES-1:0] = line_pend;
                irq_d[0] = line_pend[0] | err_pend | dma_pend;
            end
            MODE_LINE_DMA: begin
                irq_d[NUM_LINES-1:0] = line_pend;
                irq_d[0] = line_pend[0] | err_pend;
                irq_d[NUM_IRQ-1] = dma_pend;
            end
            default: irq_d = '0;
        endcase
    end

endmodule

// File: rtl/pci_irq_agg.sv
module pci_irq_agg
    import pci_irq_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 pclk,
    input  logic                 presetn,
    input  logic                 psel,
    input  logic                 penable,
    input  logic                 pwrite,
    input  logic [ADDR_W-1:0]    paddr,
    input  logic [31:0]          pwdata,
    output logic [31:0]          prdata,
    input  logic [NUM_LINES-1:0] pci_int_n,
    input  logic [NUM_EVT-1:0]   evt_pulse,
    input  logic [1:0]           irq_mode,
    output logic [NUM_IRQ-1:0]   irq_out,
    output logic                 pci_rst_req,
    output logic                 err_resp_en
);

    localparam int                WSEL_W   = ADDR_W - 2;
    localparam logic [WSEL_W-1:0] OFS_CTRL = WSEL_W'(0);
    localparam logic [WSEL_W-1:0] OFS_STAT = WSEL_W'(1);

    agg_state_t           st_d, st_q;
    ctrl_t                ctrl_q;
    logic [NUM_LINES-1:0] pins_s;
    logic [NUM_EVT-1:0]   flags_q;
    logic [NUM_EVT-1:0]   flag_clr;
    logic [NUM_LINES-1:0] line_pend;
    logic                 err_pend;
    logic                 dma_pend;
    logic [NUM_IRQ-1:0]   route_irq;
    logic [WSEL_W-1:0]    wsel;
    logic                 wr_en;

    assign wsel   = paddr[ADDR_W-1:2];
    assign wr_en  = psel & penable & pwrite;
    assign ctrl_q = st_q.ctrl;

    pci_irq_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL({NUM_LINES{1'b1}})
    ) u_sync (
        .clk  (pclk),
        .rst_n(presetn),
        .din  (pci_int_n),
        .dout (pins_s)
    );

    assign flag_clr = (wr_en && wsel == OFS_STAT)
                    ? pwdata[SB_FLAG_LO +: NUM_EVT] : '0;

    pci_irq_flags #(.N(NUM_EVT)) u_flags (
        .clk    (pclk),
        .rst_n  (presetn),
        .set_i  (evt_pulse),
        .clr_i  (flag_clr),
        .flags_q(flags_q)
    );

    // request terms from the current registered state
    always_comb begin
        line_pend = ~pins_s & ctrl_q.line_en;
        err_pend  = ctrl_q.err_ie & (flags_q[EV_PAR] | flags_q[EV_TABT] |
                                     flags_q[EV_MABT] |
                                     (ctrl_q.sig_en & flags_q[EV_SYSERR]));
        dma_pend  = flags_q[EV_DMAERR] | flags_q[EV_DMADONE];
    end

    pci_irq_route u_route (
        .mode     (irq_mode_e'(irq_mode)),
        .line_pend(line_pend),
        .err_pend (err_pend),
        .dma_pend (dma_pend),
        .irq_d    (route_irq)
    );

    always_comb begin
        st_d     = st_q;
        st_d.irq = route_irq;
        if (wr_en && wsel == OFS_CTRL) begin
            st_d.ctrl.bus_rst  = pwdata[CB_BUS_RST];
            st_d.ctrl.sig_en   = pwdata[CB_SIG_EN];
            st_d.ctrl.err_ie   = pwdata[CB_ERR_IE];
            st_d.ctrl.err_resp = pwdata[CB_ERR_RESP];
            st_d.ctrl.line_en  = pwdata[NUM_LINES-1:0];
        end
    end

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        prdata = '0;
        if (wsel == OFS_CTRL) begin
            prdata[CB_BUS_RST]      = ctrl_q.bus_rst;
            prdata[CB_SIG_EN]       = ctrl_q.sig_en;
            prdata[CB_ERR_IE]       = ctrl_q.err_ie;
            prdata[CB_ERR_RESP]     = ctrl_q.err_resp;
            prdata[NUM_LINES-1:0]   = ctrl_q.line_en;
        end else if (wsel == OFS_STAT) begin
            prdata[SB_MODE_LO +: 2]       = irq_mode;
            prdata[SB_FLAG_LO +: NUM_EVT] = flags_q;
            prdata[SB_PIN_LO +: NUM_LINES] = pins_s;
        end
    end

    assign irq_out     = st_q.irq;
    assign pci_rst_req = ctrl_q.bus_rst;
    assign err_resp_en = ctrl_q.err_resp;

endmodule

// File: rtl/pci_irq_agg_chk.sv
module pci_irq_agg_chk
    import pci_irq_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic                 pclk,
    input logic                 presetn,
    input logic                 psel,
    input logic                 penable,
    input logic                 pwrite,
    input logic [ADDR_W-1:0]    paddr,
    input logic [31:0]          prdata,
    input logic [NUM_EVT-1:0]   evt_pulse,
    input logic [1:0]           irq_mode,
    input logic [NUM_IRQ-1:0]   irq_out,
    input ctrl_t                ctrl_q,
    input logic [NUM_EVT-1:0]   flags_q,
    input logic [NUM_LINES-1:0] pins_s
);

    localparam int                WSEL_W    = ADDR_W - 2;
    localparam logic [31:0]       CTRL_RSVD = 32'h74FF_FFF0;

    logic stat_wr;
    assign stat_wr = psel && penable && pwrite &&
                     (paddr[ADDR_W-1:2] == WSEL_W'(1));

    // R4: without a status write, no flag ever falls
    a_r4_flag_sticky: assert property (@(posedge pclk) disable iff (!presetn)
        !stat_wr |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R5: an event pulse always leaves its flag set, even against a clear
    a_r5_event_wins: assert property (@(posedge pclk) disable iff (!presetn)
        (evt_pulse != '0) |=> ((flags_q & $past(evt_pulse)) == $past(evt_pulse)));

    // R6 / R12: no enabled pending line and no flag means quiet outputs
    a_r6_quiet_when_idle: assert property (@(posedge pclk) disable iff (!presetn)
        (((ctrl_q.line_en & ~pins_s) == '0) && (flags_q == '0)) |=> (irq_out == '0));

    // R7: mode 0 uses only the first output
    a_r7_single_output: assert property (@(posedge pclk) disable iff (!presetn)
        (irq_mode == 2'd0) |=> (irq_out[NUM_IRQ-1:1] == '0));

    // R8 / R10: DMA flags reach the dedicated line in the odd wide modes
    a_r8_dma_own_line: assert property (@(posedge pclk) disable iff (!presetn)
        (((irq_mode == 2'd1) || (irq_mode == 2'd3)) &&
         (flags_q[EV_DMADONE] || flags_q[EV_DMAERR])) |=> irq_out[NUM_IRQ-1]);

    // R9: mode 2 never uses the dedicated DMA line
    a_r9_no_dma_line: assert property (@(posedge pclk) disable iff (!presetn)
        (irq_mode == 2'd2) |=> !irq_out[NUM_IRQ-1]);

    // R13: status shows the mode strap
    a_r13_mode_field: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && (paddr[ADDR_W-1:2] == WSEL_W'(1))) |-> (prdata[25:24] == irq_mode));

    // R2: unimplemented control bits read as zero
    a_r2_reserved_zero: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && (paddr[ADDR_W-1:2] == WSEL_W'(0))) |-> ((prdata & CTRL_RSVD) == '0));

endmodule

bind pci_irq_agg pci_irq_agg_chk #(.ADDR_W(ADDR_W)) u_chk (
    .pclk     (pclk),
    .presetn  (presetn),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .prdata   (prdata),
    .evt_pulse(evt_pulse),
    .irq_mode (irq_mode),
    .irq_out  (irq_out),
    .ctrl_q   (ctrl_q),
    .flags_q  (flags_q),
    .pins_s   (pins_s)
);

// File: tb/sim_pci_irq_agg.sv
module sim_pci_irq_agg;

    localparam int          ADDR_W    = 4;
    localparam logic [31:0] CTRL_MASK = 32'h8B00_000F;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [31:0]       pwdata = '0;
    logic [31:0]       prdata;
    logic [3:0]        pins = 4'hF;
    logic [5:0]        evt = '0;
    logic [1:0]        mode = 2'd0;
    logic [4:0]        irq_out;
    logic              rst_req, eresp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pci_irq_agg #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u0 (
        .pclk(clk), .presetn(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pci_int_n(pins), .evt_pulse(evt), .irq_mode(mode),
        .irq_out(irq_out), .pci_rst_req(rst_req), .err_resp_en(eresp)
    );

    // routing rule from R6..R11
    function automatic logic [4:0] f_route(input logic [1:0] md, input logic [31:0] cw,
                                           input logic [5:0] fl, input logic [3:0] pn);
        logic [3:0] ln;
        logic       er, dm;
        logic [4:0] r;
        ln = ~pn & cw[3:0];
        er = cw[25] & (fl[0] | fl[1] | fl[2] | (cw[27] & fl[5]));
        dm = fl[3] | fl[4];
        r  = '0;
        case (md)
            2'd0: r[0] = (|ln) | er | dm;
            2'd1: begin r[0] = (|ln) | er; r[4] = dm; end
            2'd2: begin r[3:0] = ln; r[0] = ln[0] | er | dm; end
            default: begin r[3:0] = ln; r[0] = ln[0] | er; r[4] = dm; end
        endcase
        return r;
    endfunction

    function automatic logic [31:0] f_status(input logic [1:0] md, input logic [5:0] fl,
                                             input logic [3:0] pn);
        return {6'b0, md, 6'b0, fl, pn, 8'b0};
    endfunction

    // cycle model built from the requirements
    logic [31:0] m_ctrl;
    logic [5:0]  m_flags;
    logic [3:0]  m_s1, m_s2;
    logic [4:0]  m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl <= '0; m_flags <= '0; m_s1 <= 4'hF; m_s2 <= 4'hF; m_irq <= '0;
        end else begin
            m_s1  <= pins;
            m_s2  <= m_s1;
            m_irq <= f_route(mode, m_ctrl, m_flags, m_s2);
            if (psel && penable && pwrite && paddr[3:2] == 2'd0)
                m_ctrl <= pwdata & CTRL_MASK;
            m_flags <= (m_flags & ~((psel && penable && pwrite && paddr[3:2] == 2'd1)
                                    ? pwdata[17:12] : 6'd0)) | evt;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic apb_write(input logic [3:0] a, input logic [31:0] d, input logic [5:0] ev);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1; evt = ev;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; evt = '0;
    endtask

    task automatic apb_read(input logic [3:0] a, output logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pulse(input logic [5:0] ev);
        evt = ev;
        @(negedge clk);
        evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic [31:0] cw;
        void'($urandom(32'd20240611));
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        chk("R1 irq_out after reset", {27'b0, irq_out}, 32'h0);
        apb_read(4'h0, rd); chk("R1 control after reset", rd, 32'h0);
        apb_read(4'h4, rd); chk("R1 status after reset (R13 mode 0)", rd, 32'h0000_0F00);

        // R2 control storage and pins
        apb_write(4'h0, 32'hFFFF_FFFF, '0);
        apb_read(4'h0, rd); chk("R2 control readback", rd, 32'h8B00_000F);
        chk("R2 reset request and error response pins", {30'b0, rst_req, eresp}, 32'h3);
        apb_write(4'h0, 32'h0, '0);
        chk("R2 pins cleared", {30'b0, rst_req, eresp}, 32'h0);

        // R3 synchronizer latency
        psel = 1'b1; paddr = 4'h4;
        pins = 4'b0101;
        @(negedge clk); #1 chk("R3 status one edge after pin change", {28'b0, prdata[11:8]}, 32'hF);
        @(negedge clk); #1 chk("R3 status two edges after pin change", {28'b0, prdata[11:8]}, 32'h5);
        psel = 1'b0;

        // R6 disabled lines stay silent, R12 timing of mask/unmask
        mode = 2'd2; pins = 4'b0000;
        tick(4);
        chk("R6 all lines disabled", {27'b0, irq_out}, 32'h0);
        apb_write(4'h0, 32'h0000_0002, '0);
        chk("R12 output one cycle after enable write", {27'b0, irq_out}, 32'h0);
        tick(1);
        chk("R9 INTB on its own output", {27'b0, irq_out}, 32'h02);
        apb_write(4'h0, 32'h0, '0);
        chk("R12 output held one cycle after mask", {27'b0, irq_out}, 32'h02);
        tick(1);
        chk("R12 output drops after mask", {27'b0, irq_out}, 32'h0);
        pins = 4'hF; tick(3);

        // R4 each event sets its own flag
        for (int k = 0; k < 6; k++) begin
            pulse(6'(1 << k));
            apb_read(4'h4, rd);
            chk($sformatf("R4 flag %0d set", k), {26'b0, rd[17:12]}, 32'((1 << (k + 1)) - 1));
        end
        tick(5);
        apb_read(4'h4, rd); chk("R4 flags persist", {26'b0, rd[17:12]}, 32'h3F);

        // R5 clear semantics and collision
        apb_write(4'h4, 32'h0, '0);
        apb_read(4'h4, rd); chk("R5 zero write leaves flags", {26'b0, rd[17:12]}, 32'h3F);
        apb_write(4'h4, 32'h0000_3000, '0);
        apb_read(4'h4, rd); chk("R5 clear parity and target abort", {26'b0, rd[17:12]}, 32'h3C);
        apb_write(4'h4, 32'h0002_0000, 6'b10_0000);
        apb_read(4'h4, rd); chk("R5 event wins over same-cycle clear", {26'b0, rd[17:12]}, 32'h3C);
        apb_write(4'h4, 32'h0003_F000, '0);
        apb_read(4'h4, rd); chk("R5 clear all", {26'b0, rd[17:12]}, 32'h0);

        // R11 error enable gating
        mode = 2'd0;
        pulse(6'b00_0100);
        tick(2);
        chk("R11 master abort without error enable", {27'b0, irq_out}, 32'h0);
        apb_write(4'h0, 32'h0200_0000, '0);
        tick(1);
        chk("R11 master abort with error enable", {27'b0, irq_out}, 32'h1);
        apb_write(4'h4, 32'h0003_F000, '0);
        pulse(6'b10_0000);
        tick(2);
        chk("R11 system error without signalling enable", {27'b0, irq_out}, 32'h0);
        apb_write(4'h0, 32'h0A00_0000, '0);
        tick(1);
        chk("R11 system error with signalling enable", {27'b0, irq_out}, 32'h1);
        apb_write(4'h4, 32'h0003_F000, '0);

        // R7..R10 routing per mode
        cw = 32'h0A00_000F;
        apb_write(4'h0, cw, '0);
        for (int m = 0; m < 4; m++) begin
            string tg;
            tg = (m == 0) ? "R7" : (m == 1) ? "R8" : (m == 2) ? "R9" : "R10";
            mode = 2'(m);
            pins = 4'b0110; tick(4);
            chk($sformatf("%s lines A and D pending", tg), {27'b0, irq_out},
                {27'b0, f_route(2'(m), cw, 6'h0, 4'b0110)});
            pins = 4'hF; tick(3);
            pulse(6'b01_0000); tick(1);
            chk($sformatf("%s DMA done", tg), {27'b0, irq_out},
                {27'b0, f_route(2'(m), cw, 6'b01_0000, 4'hF)});
            apb_write(4'h4, 32'h0003_F000, '0);
            pulse(6'b00_0010); tick(1);
            chk($sformatf("%s target abort", tg), {27'b0, irq_out},
                {27'b0, f_route(2'(m), cw, 6'b00_0010, 4'hF)});
            apb_write(4'h4, 32'h0003_F000, '0);
            pins = 4'b1011; tick(4);
            chk($sformatf("%s line C pending", tg), {27'b0, irq_out},
                {27'b0, f_route(2'(m), cw, 6'h0, 4'b1011)});
            pins = 4'hF; tick(3);
        end

        // random phase against the model (R12, R5, R13)
        for (int i = 0; i < 3000; i++) begin
            int ph;
            ph = i % 3;
            @(negedge clk);
            chk("R12 random irq_out", {27'b0, irq_out}, {27'b0, m_irq});
            if ($urandom % 8 == 0) pins = 4'($urandom);
            evt = ($urandom % 6 == 0) ? 6'($urandom) : 6'd0;
            if ($urandom % 64 == 0) mode = 2'($urandom);
            if (ph == 0) begin
                psel = 1'b1; penable = 1'b0;
                pwrite = ($urandom % 2 == 0);
                paddr = ($urandom % 2 == 0) ? 4'h4 : 4'h0;
                pwdata = $urandom;
            end else if (ph == 1) begin
                penable = 1'b1;
                #1;
                if (!pwrite) begin
                    if (paddr == 4'h4)
                        chk("R13 random status read", prdata, f_status(mode, m_flags, m_s2));
                    else
                        chk("R2 random control read", prdata, m_ctrl);
                end
            end else begin
                psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
            end
        end
        evt = '0;
        tick(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule